// File: doc/BRIEF.md
# GPIO Bank with Dual-CPU Interrupt Summaries

This block is a bank of 32 general-purpose I/O lines. It has a small register file that is read and written one word at a time. Software can drive output values, choose the direction of each line, invert the sense of each input and read the raw synchronised pin levels. Each pin input passes through a two-flop synchroniser. The polarity-adjusted level of an input line then feeds two interrupt paths:

- **Level path:** the adjusted level serves as the level source directly, with no latch.
- **Edge path:** a 0-to-1 change of the adjusted level sets a sticky bit in the edge cause register. Software clears that bit by writing a zero to it.

Two CPUs each own a private edge mask and a private level mask. Each CPU receives one registered interrupt per group of eight lines. That interrupt is the OR, over the group, of the masked edge causes and the masked level sources. Lines configured as outputs never act as interrupt sources.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the direction register (offset 0x04) reads all ones, so every line is an input. Every other register, `pin_out` and all interrupt outputs are zero.
- R2: The read/write registers round-trip the written value on a read at the same offset in any later cycle. These are data out 0x00, direction 0x04, blink storage 0x08, polarity 0x0C, CPU0 edge mask 0x18, CPU0 level mask 0x1C, CPU1 edge mask 0x30 and CPU1 level mask 0x34. `pin_out` equals data out, and `pin_dir_in` equals the direction register, where bit = 1 means input.
- R3: Offset 0x10 returns the raw pin value, without polarity applied. It reflects a pin change after two clock edges, and writes to 0x10 have no effect.
- R4: The level source of line i is the synchronised pin XOR polarity bit i, gated by direction bit i. It is not latched: it follows the pin in both directions.
- R5: A 0-to-1 change of the polarity-adjusted level on an input line sets bit i of the edge cause register (0x14). The bit stays set after the line returns low. A 1-to-0 change sets nothing.
- R6: Writing 0x14 clears each bit written as 0 and keeps each bit written as 1. An edge that arrives in the same cycle as a clearing write leaves its bit set.
- R7: A line whose direction bit is 0 never sets an edge cause bit and never contributes a level source.
- R8: CPU0 uses masks 0x18 (edge) and 0x1C (level) and drives `irq_cpu0`. CPU1 uses masks 0x30 (edge) and 0x34 (level) and drives `irq_cpu1`. A mask of one CPU has no effect on the outputs of the other.
- R9: Output bit g of a CPU is the OR over lines 8g to 8g+7 of (edge cause AND edge mask) OR (level source AND level mask). It is registered, so it rises three clock edges after a pin change on the level path.
- R10: Reads from any other offset, including unaligned ones, return zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not selected |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output data to the pads |
| pin_dir_in | output | 32 | Per-line direction, 1 = input |
| irq_cpu0 | output | 4 | CPU0 group interrupts |
| irq_cpu1 | output | 4 | CPU1 group interrupts |

## Verification
The bench builds the block with its default parameters: 32 lines in four groups of eight, and an 8-bit offset. This size makes it cheap to sweep every line individually through the level and edge paths for both CPUs. It also makes it cheap to write every one of the 256 offsets, confirming that only the mapped ones hold state. Cycle-exact probes cover the synchroniser and interrupt register latency, as well as the clash between an arriving edge and a clearing write.

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NLINES = 32,
  parameter int GRP    = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NLINES-1:0] bus_wdata,
  output logic [NLINES-1:0] bus_rdata,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_dir_in,
  output logic [NLINES/GRP-1:0] irq_cpu0,
  output logic [NLINES/GRP-1:0] irq_cpu1
);
  localparam int NGRP = NLINES / GRP;
  localparam logic [ADDR_W-1:0] A_DOUT  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_BLINK = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_POL   = ADDR_W'('h0C);
  localparam logic [ADDR_W-1:0] A_DIN   = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] A_EM0   = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] A_LM0   = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] A_EM1   = ADDR_W'('h30);
  localparam logic [ADDR_W-1:0] A_LM1   = ADDR_W'('h34);

  logic [NLINES-1:0] dout_q, dir_q, blink_q, pol_q, cause_q;
  logic [NLINES-1:0] em0_q, lm0_q, em1_q, lm1_q;
  logic [NLINES-1:0] sync1_q, sync2_q, prev_q;
  logic [NLINES-1:0] adj, lvl_src, edge_ev, src0, src1, any_src;
  logic              wr, wr_cause;

  assign wr       = bus_sel & bus_we;
  assign wr_cause = wr && (bus_addr == A_CAUSE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= adj;
    end
  end

  assign adj     = sync2_q ^ pol_q;
  assign lvl_src = adj & dir_q;
  assign edge_ev = adj & ~prev_q & dir_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout_q  <= '0;
      dir_q   <= '1;
      blink_q <= '0;
      pol_q   <= '0;
      em0_q   <= '0;
      lm0_q   <= '0;
      em1_q   <= '0;
      lm1_q   <= '0;
    end else if (wr) begin
      case (bus_addr)
        A_DOUT:  dout_q  <= bus_wdata;
        A_DIR:   dir_q   <= bus_wdata;
        A_BLINK: blink_q <= bus_wdata;
        A_POL:   pol_q   <= bus_wdata;
        A_EM0:   em0_q   <= bus_wdata;
        A_LM0:   lm0_q   <= bus_wdata;
        A_EM1:   em1_q   <= bus_wdata;
        A_LM1:   lm1_q   <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= (wr_cause ? (cause_q & bus_wdata) : cause_q) | edge_ev;
  end

  assign src0    = (cause_q & em0_q) | (lvl_src & lm0_q);
  assign src1    = (cause_q & em1_q) | (lvl_src & lm1_q);
  assign any_src = cause_q | lvl_src;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        irq_cpu0[g] <= 1'b0;
        irq_cpu1[g] <= 1'b0;
      end else begin
        irq_cpu0[g] <= |src0[g*GRP +: GRP];
        irq_cpu1[g] <= |src1[g*GRP +: GRP];
      end
    end

    p_irq_has_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_cpu0[g] || irq_cpu1[g]) |-> $past(|any_src[g*GRP +: GRP]))
      else $error("group irq without a pending source");
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (bus_addr)
        A_DOUT:  bus_rdata = dout_q;
        A_DIR:   bus_rdata = dir_q;
        A_BLINK: bus_rdata = blink_q;
        A_POL:   bus_rdata = pol_q;
        A_DIN:   bus_rdata = sync2_q;
        A_CAUSE: bus_rdata = cause_q;
        A_EM0:   bus_rdata = em0_q;
        A_LM0:   bus_rdata = lm0_q;
        A_EM1:   bus_rdata = em1_q;
        A_LM1:   bus_rdata = lm1_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign pin_out    = dout_q;
  assign pin_dir_in = dir_q;

  p_edge_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_ev != '0) |=> ((cause_q & $past(edge_ev)) == $past(edge_ev)))
    else $error("arriving edge lost");

  p_clear_by_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cause_q) & ~cause_q & ~($past(wr_cause) ? ~$past(bus_wdata) : '0)) == '0)
    else $error("cause bit dropped without a clearing write");

  p_output_line_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q & ~$past(cause_q) & ~$past(dir_q)) == '0)
    else $error("cause raised on an output line");

  p_unaligned_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0))
    else $error("unaligned read returned data");
endmodule

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, pins = '0, pout, pdir;
  logic [3:0]  irq0, irq1;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .pin_in(pins), .pin_out(pout),
    .pin_dir_in(pdir), .irq_cpu0(irq0), .irq_cpu1(irq1)
  );

  function automatic bit mapped(input logic [7:0] a);
    return a inside {8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h30, 8'h34};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd_now(input logic [7:0] a, output logic [31:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    @(negedge clk);
    rd_now(a, d);
    chk(req, d, exp);
  endtask

  task automatic irqchk(input string req, input logic [3:0] e0, input logic [3:0] e1);
    @(negedge clk);
    chk({req, " cpu0"}, {28'b0, irq0}, {28'b0, e0});
    chk({req, " cpu1"}, {28'b0, irq1}, {28'b0, e1});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  rw [8] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h18, 8'h1C, 8'h30, 8'h34};
    waitc(5);
    rst_n = 1'b1;

    // R1 reset state
    irqchk("R1 irq reset", 4'h0, 4'h0);
    chk("R1 pin_out reset", pout, 32'h0);
    chk("R1 pin_dir_in reset", pdir, 32'hFFFF_FFFF);
    for (int a = 0; a < 256; a += 4)
      if (mapped(8'(a))) rdchk("R1 reg reset", 8'(a), (a == 4) ? 32'hFFFF_FFFF : 32'h0);

    // R10 every unmapped offset: write ignored, read zero
    for (int a = 0; a < 256; a++) begin
      if (!mapped(8'(a))) begin
        wr(8'(a), 32'hFFFF_FFFF);
        rdchk("R10 unmapped read", 8'(a), 32'h0);
      end
    end
    for (int a = 0; a < 256; a += 4)
      if (mapped(8'(a))) rdchk("R10 mapped unchanged", 8'(a), (a == 4) ? 32'hFFFF_FFFF : 32'h0);
    wr(8'h10, 32'hFFFF_FFFF);
    rdchk("R3 din write ignored", 8'h10, 32'h0);

    // R2 round trip
    for (int p = 0; p < 3; p++) begin
      for (int k = 0; k < 8; k++) begin
        logic [31:0] v;
        v = (32'hA5C3_0F96 << p) ^ {24'b0, rw[k]} ^ (p == 2 ? 32'hFFFF_FFFF : 32'h0);
        wr(rw[k], v);
        rdchk("R2 readback", rw[k], v);
        if (rw[k] == 8'h00) chk("R2 pin_out", pout, v);
        if (rw[k] == 8'h04) chk("R2 pin_dir_in", pdir, v);
      end
    end
    for (int k = 0; k < 8; k++) wr(rw[k], (rw[k] == 8'h04) ? 32'hFFFF_FFFF : 32'h0);
    waitc(4);
    wr(8'h14, 32'h0);
    waitc(2);
    irqchk("R2 restored", 4'h0, 4'h0);

    // R3 two-flop latency and raw value regardless of polarity
    wr(8'h0C, 32'hFFFF_0000);
    @(negedge clk); pins = 32'h1234_ABCD;
    @(negedge clk); rd_now(8'h10, d); chk("R3 din after one edge", d, 32'h0);
    @(negedge clk); rd_now(8'h10, d); chk("R3 din after two edges", d, 32'h1234_ABCD);
    pins = 32'h0;
    wr(8'h0C, 32'h0);
    waitc(4);
    wr(8'h14, 32'h0);

    // R4 R8 R9 level path per line, both CPUs
    for (int i = 0; i < 32; i++) begin
      logic [31:0] b;
      logic [3:0]  g;
      b = 32'h1 << i;
      g = 4'h1 << (i / 8);
      wr(8'h1C, b);
      pins = b;
      waitc(4);
      irqchk("R4 level cpu0", g, 4'h0);
      wr(8'h1C, 32'h0); wr(8'h34, b);
      waitc(2);
      irqchk("R8 level cpu1 only", 4'h0, g);
      wr(8'h0C, b);
      waitc(2);
      irqchk("R4 inverted level low", 4'h0, 4'h0);
      pins = 32'h0;
      waitc(4);
      irqchk("R4 inverted level high", 4'h0, g);
      wr(8'h0C, 32'h0);
      waitc(2);
      irqchk("R4 level not latched", 4'h0, 4'h0);
      wr(8'h34, 32'h0);
      wr(8'h14, 32'h0);
    end

    // R5 R6 R8 R9 edge path per line
    for (int i = 0; i < 32; i++) begin
      logic [31:0] b;
      logic [3:0]  g;
      b = 32'h1 << i;
      g = 4'h1 << (i / 8);
      wr(8'h18, b);
      pins = b; waitc(3); pins = 32'h0; waitc(4);
      rdchk("R5 edge latched", 8'h14, b);
      irqchk("R9 edge group cpu0", g, 4'h0);
      wr(8'h14, 32'hFFFF_FFFF);
      rdchk("R6 write one keeps", 8'h14, b);
      wr(8'h14, ~b);
      waitc(2);
      rdchk("R6 write zero clears", 8'h14, 32'h0);
      irqchk("R6 irq drops after clear", 4'h0, 4'h0);
      wr(8'h18, 32'h0); wr(8'h30, b);
      pins = b; waitc(4);
      wr(8'h14, 32'h0);
      pins = 32'h0; waitc(4);
      rdchk("R5 falling edge ignored", 8'h14, 32'h0);
      pins = b; waitc(3); pins = 32'h0; waitc(4);
      irqchk("R8 edge cpu1 only", 4'h0, g);
      wr(8'h30, 32'h0);
      wr(8'h14, 32'h0);
    end

    // R7 output lines never raise causes
    wr(8'h04, 32'h0);
    wr(8'h18, 32'hFFFF_FFFF); wr(8'h1C, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF); wr(8'h34, 32'hFFFF_FFFF);
    pins = 32'hA5A5_5A5A; waitc(4);
    rdchk("R7 no cause on outputs", 8'h14, 32'h0);
    irqchk("R7 no irq on outputs", 4'h0, 4'h0);
    rdchk("R3 din on output lines", 8'h10, 32'hA5A5_5A5A);
    pins = 32'hFFFF_FFFF;
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h04, 32'h0000_00FF);
    waitc(3);
    irqchk("R7 inverted input group quiet", 4'h0, 4'h0);
    pins = 32'h0; waitc(4);
    rdchk("R7 only input lines latch", 8'h14, 32'h0000_00FF);
    irqchk("R7 only input group fires", 4'h1, 4'h1);
    wr(8'h18, 32'h0); wr(8'h1C, 32'h0); wr(8'h30, 32'h0); wr(8'h34, 32'h0);
    wr(8'h0C, 32'h0); wr(8'h04, 32'hFFFF_FFFF);
    waitc(4);
    wr(8'h14, 32'h0);

    // R9 exact latency on the level path
    wr(8'h1C, 32'h1);
    @(negedge clk); pins = 32'h1;
    @(negedge clk); chk("R9 irq after one edge", {28'b0, irq0}, 32'h0);
    @(negedge clk); chk("R9 irq after two edges", {28'b0, irq0}, 32'h0);
    @(negedge clk); chk("R9 irq after three edges", {28'b0, irq0}, 32'h1);
    pins = 32'h0;
    wr(8'h1C, 32'h0);
    waitc(4);
    wr(8'h14, 32'h0);

    // R6 edge arriving with a clearing write
    pins = 32'h20; waitc(4);
    rdchk("R6 setup bit5", 8'h14, 32'h20);
    @(negedge clk); pins = 32'h220;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk); sel = 1'b1; we = 1'b1; addr = 8'h14; wdata = 32'h0;
    @(negedge clk); sel = 1'b0; we = 1'b0;
    rdchk("R6 edge beats clear", 8'h14, 32'h200);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule